// File: doc/BRIEF.md
# Serial Packet Receiver with CRC16 Check

This block receives data packets one bit per clock on a single serial line whose idle level is high. A low bit seen while idle marks the start of a packet. The block then gathers the payload, most significant bit first, into bytes. It hands each finished byte to the next stage as a one-cycle strobe. No buffering is kept beyond that single byte.

Two framing modes are chosen at the start bit. Fixed-length mode expects a configured number of payload bytes, then a 16-bit CRC, then an end bit. The block checks both the CRC and the end bit. Open-ended mode has no length and no CRC. The payload runs until the upstream controller raises a stop request. Reception then ends after the byte in progress, and the next bit must be the end bit.

When a packet finishes, a one-cycle completion pulse appears together with the error flags that apply to it. The receiver is ready for a new start bit in the very next cycle.

Top module: `pkt_rx`

## Requirements
- R1: After reset, byte_vld, pkt_done, crc_err and frm_err are 0 and byte_out is 0. While sdi stays 1 in idle, no byte or completion is produced, whatever the level of stop.
- R2: Payload bits are assembled most significant bit first. Each byte appears on byte_out with byte_vld high for exactly one cycle. This is the cycle after its eighth bit is sampled.
- R3: With fixed_mode=1, exactly blk_len bytes are delivered. blk_len is in bytes, from 1 to 2048 (2048 is encoded as 12'h800). It is latched with the start bit, so later changes have no effect on the packet in progress.
- R4: In fixed-length mode, a 16-bit CRC follows the payload, most significant bit first. The block computes the CRC over the payload bits only. It uses polynomial x^16+x^12+x^5+1 (0x1021), starting from zero. If the received value differs, crc_err is 1 in the pkt_done cycle.
- R5: The bit after the last payload byte (open-ended mode) or after the CRC (fixed-length mode) is the end bit. If it is 0, frm_err is 1 in the pkt_done cycle.
- R6: With fixed_mode=0, there is no CRC field and crc_err is never set. Once stop has been seen high during a byte, reception ends after that byte, and the next bit is the end bit.
- R7: pkt_done is a one-cycle pulse in the cycle after the end bit is sampled. Error flags are only ever high together with pkt_done. A start bit in the cycle right after the end bit begins a new packet.
- R8: fixed_mode is latched with the start bit. Changing it during a packet does not alter that packet's framing.
- R9: In fixed-length mode the stop input has no effect on the number of bytes delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data line, idle high |
| fixed_mode | input | 1 | 1 = fixed-length with CRC, 0 = open-ended; latched at start bit |
| blk_len | input | 12 | Payload length in bytes for fixed-length mode; latched at start bit |
| stop | input | 1 | Request to end an open-ended packet after the current byte |
| byte_out | output | 8 | Last completed payload byte |
| byte_vld | output | 1 | One-cycle strobe qualifying byte_out |
| pkt_done | output | 1 | One-cycle pulse after the end bit |
| crc_err | output | 1 | CRC mismatch, valid with pkt_done |
| frm_err | output | 1 | End bit was low, valid with pkt_done |

## Verification
The hardest cases to reach from the pins are framing boundaries. One is a stop request arriving on the very last bit of a byte. Another is a new start bit arriving directly after an end bit, with no idle gap. A third is a fault in a single CRC bit or in the end bit. The stimulus builds each packet bit by bit. Directed packets place stop on the first and last bit of a byte and chain two packets with no gap. Seeded random packets mix lengths, modes, stop positions and injected faults. During each packet, the mode and length inputs are changed after the start bit to show that the latched values rule the framing.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CRC  = 2'd2,
    ST_END  = 2'd3
  } rx_state_t;

  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/pkt_rx_crc.sv
module pkt_rx_crc #(
  parameter int               W    = 16,
  parameter logic [W-1:0]     POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] nxt;

  assign fb = crc[W-1] ^ bit_in;

  // one LFSR tap per bit position
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = fb;
    end else begin : g_hi
      assign nxt[i] = crc[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= nxt;
  end
endmodule

// File: rtl/pkt_rx_shift.sv
module pkt_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[W-2:0], bit_in};
  end
endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  input  logic              fixed_mode,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              stop,
  input  logic [BYTE_W-1:0] data_sh,
  input  logic [CRC_W-1:0]  rx_crc,
  input  logic [CRC_W-1:0]  calc_crc,
  output logic              crc_clr,
  output logic              data_en,
  output logic              crc_sh_en,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              pkt_done,
  output logic              crc_err,
  output logic              frm_err
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam int CRC_CW = $clog2(CRC_W);
  localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(BYTE_W - 1);
  localparam logic [CRC_CW-1:0] CRC_LAST = CRC_CW'(CRC_W - 1);
  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);

  rx_state_t          st;
  logic               mode_q;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   byte_cnt;
  logic [BIT_CW-1:0]  bit_cnt;
  logic [CRC_CW-1:0]  crc_cnt;
  logic               stop_seen;
  logic               byte_last;

  assign crc_clr   = (st == ST_IDLE) && !sdi;
  assign data_en   = (st == ST_DATA);
  assign crc_sh_en = (st == ST_CRC);
  assign byte_last = (bit_cnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode_q    <= 1'b0;
      len_q     <= '0;
      byte_cnt  <= '0;
      bit_cnt   <= '0;
      crc_cnt   <= '0;
      stop_seen <= 1'b0;
      byte_out  <= '0;
      byte_vld  <= 1'b0;
      pkt_done  <= 1'b0;
      crc_err   <= 1'b0;
      frm_err   <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      pkt_done <= 1'b0;
      crc_err  <= 1'b0;
      frm_err  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (!sdi) begin
            st        <= ST_DATA;
            mode_q    <= fixed_mode;
            len_q     <= blk_len;
            byte_cnt  <= '0;
            bit_cnt   <= '0;
            stop_seen <= 1'b0;
          end
        end
        ST_DATA: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (!mode_q && stop) stop_seen <= 1'b1;
          if (byte_last) begin
            byte_out <= {data_sh[BYTE_W-2:0], sdi};
            byte_vld <= 1'b1;
            byte_cnt <= byte_cnt + 1'b1;
            if (mode_q) begin
              if (byte_cnt == len_q - LEN_ONE) begin
                st      <= ST_CRC;
                crc_cnt <= '0;
              end
            end else if (stop_seen || stop) begin
              st <= ST_END;
            end
          end
        end
        ST_CRC: begin
          crc_cnt <= crc_cnt + 1'b1;
          if (crc_cnt == CRC_LAST) st <= ST_END;
        end
        ST_END: begin
          pkt_done <= 1'b1;
          frm_err  <= !sdi;
          crc_err  <= mode_q && (rx_crc != calc_crc);
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);

  // R7
  err_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_err || frm_err) |-> pkt_done);

  // R6
  stream_nocrc_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && !mode_q) |-> !crc_err);

  // R3
  crc_only_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CRC) |-> mode_q);

  // R2
  byte_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> !pkt_done);
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx
  import pkt_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  input  logic              fixed_mode,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              stop,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_vld,
  output logic              pkt_done,
  output logic              crc_err,
  output logic              frm_err
);
  logic              crc_clr;
  logic              data_en;
  logic              crc_sh_en;
  logic [BYTE_W-1:0] data_sh;
  logic [CRC_W-1:0]  rx_crc;
  logic [CRC_W-1:0]  calc_crc;

  pkt_rx_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(data_en),
    .bit_in(sdi), .crc(calc_crc)
  );

  pkt_rx_shift #(.W(BYTE_W)) u_dsh (
    .clk(clk), .rst(rst), .en(data_en), .bit_in(sdi), .q(data_sh)
  );

  pkt_rx_shift #(.W(CRC_W)) u_csh (
    .clk(clk), .rst(rst), .en(crc_sh_en), .bit_in(sdi), .q(rx_crc)
  );

  pkt_rx_ctrl #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .sdi(sdi), .fixed_mode(fixed_mode),
    .blk_len(blk_len), .stop(stop), .data_sh(data_sh),
    .rx_crc(rx_crc), .calc_crc(calc_crc), .crc_clr(crc_clr),
    .data_en(data_en), .crc_sh_en(crc_sh_en), .byte_out(byte_out),
    .byte_vld(byte_vld), .pkt_done(pkt_done), .crc_err(crc_err),
    .frm_err(frm_err)
  );
endmodule

// File: tb/pkt_rx_test.sv
module pkt_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdi = 1'b1;
  logic        fixed_mode = 1'b0;
  logic [11:0] blk_len = 12'd1;
  logic        stop = 1'b0;
  logic [7:0]  byte_out;
  logic        byte_vld, pkt_done, crc_err, frm_err;

  int total = 0;
  int bad = 0;

  logic [7:0] pl [0:2047];
  logic [7:0] rx_buf [0:2047];
  int  rx_cnt = 0;
  int  done_cnt = 0;
  int  stray_err = 0;
  logic last_crc = 1'b0, last_frm = 1'b0;

  // per-packet settings
  bit  cur_mode;
  int  cur_len;       // fixed: byte count; stream: stop byte index + 1
  int  stop_bit;      // bit index (0 = first sent) within last stream byte
  bit  corrupt_crc;
  int  corrupt_pos;
  bit  bad_end;
  bit  toggle_stop;

  pkt_rx uut (
    .clk(clk), .rst(rst), .sdi(sdi), .fixed_mode(fixed_mode),
    .blk_len(blk_len), .stop(stop), .byte_out(byte_out),
    .byte_vld(byte_vld), .pkt_done(pkt_done), .crc_err(crc_err),
    .frm_err(frm_err)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_vld) begin
        if (rx_cnt < 2048) rx_buf[rx_cnt] = byte_out;
        rx_cnt = rx_cnt + 1;
      end
      if (pkt_done) begin
        done_cnt = done_cnt + 1;
        last_crc = crc_err;
        last_frm = frm_err;
      end
      if ((crc_err || frm_err) && !pkt_done) stray_err = stray_err + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic drive_bit(input logic b);
    @(negedge clk); #1;
    sdi = b;
    if (toggle_stop) stop = 1'($urandom);
  endtask

  // sends one packet; start bit already driven if skip_start
  task automatic send_packet(input bit skip_start, input bit chain);
    logic [15:0] c;
    int d0;
    d0 = done_cnt;
    c = 16'h0000;
    if (!skip_start) begin
      @(negedge clk); #1;
      sdi = 1'b0;
      fixed_mode = cur_mode;
      blk_len = 12'(cur_len);
    end
    for (int i = 0; i < cur_len; i++) begin
      for (int k = 0; k < 8; k++) begin
        drive_bit(pl[i][7-k]);
        c = crc_step(c, pl[i][7-k]);
        if (i == 0 && k == 0) begin
          // R3 R8: changes after the start bit must not matter
          fixed_mode = ~cur_mode;
          blk_len = 12'($urandom_range(1, 4000));
        end
        if (!cur_mode && i == cur_len - 1 && k == stop_bit) stop = 1'b1;
      end
    end
    if (cur_mode) begin
      if (corrupt_crc) c[corrupt_pos] = ~c[corrupt_pos];
      for (int k = 15; k >= 0; k--) drive_bit(c[k]);
    end
    drive_bit(bad_end ? 1'b0 : 1'b1);
    @(negedge clk); #1;
    stop = 1'b0;
    toggle_stop = 1'b0;
    fixed_mode = cur_mode;
    blk_len = 12'(cur_len);
    sdi = chain ? 1'b0 : 1'b1;
    // R7 completion pulse seen once right after the end bit
    check("R7 done count", done_cnt - d0, 1);
    check(cur_mode ? "R3 byte count" : "R6 byte count", rx_cnt, cur_len);
    begin
      int mism;
      mism = 0;
      for (int i = 0; i < cur_len && i < rx_cnt; i++)
        if (rx_buf[i] != pl[i]) begin
          if (mism == 0)
            $display("FAIL R2 byte %0d: actual=%02h expected=%02h", i, rx_buf[i], pl[i]);
          mism++;
        end
      total = total + 1;
      if (mism != 0) bad = bad + 1;
    end
    check(cur_mode ? "R4 crc_err" : "R6 crc_err", int'(last_crc), int'(cur_mode && corrupt_crc));
    check("R5 frm_err", int'(last_frm), int'(bad_end));
    rx_cnt = 0;
  endtask

  task automatic fill(input int n, input int kind);
    for (int i = 0; i < n; i++)
      pl[i] = (kind == 0) ? 8'($urandom) : (kind == 1 ? 8'h00 : 8'hFF);
  endtask

  task automatic setup(input bit m, input int n, input int sb, input bit cc,
                       input bit be, input bit ts);
    cur_mode = m; cur_len = n; stop_bit = sb; corrupt_crc = cc;
    corrupt_pos = $urandom_range(0, 15); bad_end = be; toggle_stop = ts;
  endtask

  initial begin
    #1500000;
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed);
    toggle_stop = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 byte_vld", int'(byte_vld), 0);
    check("R1 pkt_done", int'(pkt_done), 0);
    check("R1 errs", int'(crc_err | frm_err), 0);
    check("R1 byte_out", int'(byte_out), 0);
    // R1 idle with stop toggling
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      stop = 1'($urandom);
    end
    @(negedge clk); #1;
    stop = 1'b0;
    check("R1 idle bytes", rx_cnt, 0);
    check("R1 idle done", done_cnt, 0);

    // R3 R4 shortest fixed packet, good then bad CRC
    fill(1, 0); setup(1, 1, 0, 0, 0, 0); send_packet(0, 0);
    fill(1, 1); setup(1, 1, 0, 1, 0, 0); send_packet(0, 0);
    // R5 bad end bit in fixed mode
    fill(3, 2); setup(1, 3, 0, 0, 1, 0); send_packet(0, 0);
    // R3 R9 maximum length with stop noise
    fill(2048, 0); setup(1, 2048, 0, 0, 0, 1); send_packet(0, 0);
    // R6 stop on first bit of first byte; on last bit of a later byte
    fill(1, 0); setup(0, 1, 0, 0, 0, 0); send_packet(0, 0);
    fill(5, 0); setup(0, 5, 7, 0, 0, 0); send_packet(0, 0);
    // R5 R6 bad end in stream mode
    fill(2, 0); setup(0, 2, 3, 0, 1, 0); send_packet(0, 0);
    // R7 back to back packets
    fill(4, 0); setup(1, 4, 0, 0, 0, 0); send_packet(0, 1);
    send_packet(1, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      bit m;
      int len;
      m = 1'($urandom);
      len = $urandom_range(1, 64);
      fill(len, 0);
      setup(m, len, $urandom_range(0, 7), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) == 0), m & 1'($urandom));
      send_packet(0, 0);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk); #1;
      end
    end
    check("R7 stray error flags", stray_err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule